// File: doc/BRIEF.md
# Instruction Line Fetch Unit with Shared Retry Slot

This block sits at the front of a multi-threaded instruction pipeline. It keeps one line buffer for each thread. Each buffer holds a whole cache line, a block-aligned tag and a valid bit. When a thread asks to fetch, the block looks up the line that holds the thread's PC. On a hit it delivers a group of 32-bit instructions in the next cycle. On a miss it sends a line read over a valid/ready request port. Each request carries the thread number and a request ID. A response is accepted only if it matches the request that is still outstanding. Any other response is flagged as stale and discarded.

If the memory side refuses a request, the request moves into one retry slot that all threads share. While the slot is busy the whole block counts as cache-blocked. A squash from later in the pipeline redirects a thread's PC. The squash also drops that thread's outstanding request and, if the thread owns the retry slot, empties the slot. Branch prediction lives outside the block. For each output slot the predictor supplies the next PC it expects. The block stops the group at the first slot whose predicted next PC is not the sequential one.

Top module: `ifu_line_fetch`

## Requirements
- R1: A line request address is the fetching thread's PC with its low OFF_W bits (log2 of the line size in bytes) cleared. No request is made when that thread's buffer is valid and its tag equals this address. A hit of this kind delivers instructions instead.
- R2: When a request is attempted, the thread's buffer tag takes the request address and its valid bit clears. The thread then takes no further fetch action until its response arrives. A response with the matching thread and ID fills the buffer, and the next fetch of that line hits.
- R3: If a request is refused (req_rdy low), it is held in the single retry slot. From the next cycle on, it is presented with the same address, thread and ID until it is accepted or squashed, and the block is cache-blocked.
- R4: When the held request is accepted, the slot empties, the blocked state clears, and the owning thread waits for its response.
- R5: A squash (flush_vld) loads the thread's PC with flush_pc. If that thread owns the retry slot, the slot is emptied. The blocked state then lasts until the next cycle in which req_rdy is high while no request is held.
- R6: rsp_stale pulses in the same cycle as a response that is discarded. A response is discarded unless its thread is waiting for a response, the ID matches, and the thread is not being squashed in that cycle. A squash forgets the thread's outstanding request.
- R7: No request is made and no instructions are delivered while the block is cache-blocked. The same holds while intr_pend is high and the fetching thread's PC has its two low bits at zero.
- R8: On a hit, extraction starts at word pc[OFF_W-1:2] of the line. It delivers up to FETCH_W words and stops early at the end of the line. out_vld, out_cnt, out_tid, out_insts and out_pcs appear one cycle after the fetch. Slot PCs run in steps of 4, and the thread's PC advances past the last slot.
- R9: Slot i is a predicted branch when its pred_npc entry differs from its PC plus 4. That slot is still delivered but is the last one. The thread's PC becomes that pred_npc entry.
- R10: Slot i uses bits [32i +: 32] of out_insts and bits [AW·i +: AW] of out_pcs and pred_npc. Slots beyond out_cnt read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_go | input | 1 | Fetch request for thread fetch_tid this cycle |
| fetch_tid | input | TIDW | Thread to fetch |
| fetch_pc | output | AW | Current PC of thread fetch_tid (for the predictor) |
| pred_npc | input | FETCH_W·AW | Predicted next PC for each output slot |
| intr_pend | input | 1 | Interrupt pending, holds fetch of aligned PCs |
| flush_vld | input | 1 | Squash request |
| flush_tid | input | TIDW | Thread being squashed |
| flush_pc | input | AW | Redirect PC |
| req_vld | output | 1 | Line read request valid |
| req_rdy | input | 1 | Memory side accepts the request |
| req_addr | output | AW | Line-aligned request address |
| req_tid | output | TIDW | Requesting thread |
| req_id | output | ID_W | Request ID |
| rsp_vld | input | 1 | Line response valid |
| rsp_tid | input | TIDW | Response thread |
| rsp_id | input | ID_W | Response ID |
| rsp_data | input | LINE_WORDS·32 | Line data, word w at bits [32w +: 32] |
| rsp_stale | output | 1 | Response discarded this cycle |
| out_vld | output | 1 | Instruction group valid |
| out_tid | output | TIDW | Thread of the group |
| out_cnt | output | CNT_W | Number of valid slots |
| out_insts | output | FETCH_W·32 | Instruction words |
| out_pcs | output | FETCH_W·AW | PC of each slot |

## Verification
Request fields (req_vld, req_addr, req_tid, req_id) and rsp_stale are combinational, so they are due in the same cycle as the fetch or response that causes them. The bench samples them on the falling edge of that cycle. Instruction groups are registered and are due one cycle after the fetch. The driver pushes the expected group into a queue during the fetch cycle, and a monitor pops and compares it at the next falling edge. Any group that appears while the queue is empty, for example one produced while blocked, counts as a failure. A filled line counts as usable from the cycle after its response, and the hit check is made there.

// File: rtl/ifu_pkg.sv
// Package: shared types for the instruction line fetch unit.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ifu_pkg;

    // Per-thread fetch state
    typedef enum logic [1:0] {
        TS_RUN        = 2'd0,  // may fetch or request
        TS_WAIT_RSP   = 2'd1,  // request sent, waiting for the line
        TS_WAIT_RETRY = 2'd2   // request refused, parked in retry slot
    } thr_st_e;

endpackage

// File: rtl/ifu_line_buf.sv
// Module: per-thread line buffers with tag and valid bit.
// A tag write sets the tag and clears valid; a fill sets valid and data.
// Assumes tag write and fill never target the same thread in one cycle.
module ifu_line_buf #(
    parameter int N_THR     = 2,
    parameter int AW        = 32,
    parameter int LINE_BITS = 256,
    parameter int TIDW      = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tag_we,
    input  logic [TIDW-1:0]      tag_tid,
    input  logic [AW-1:0]        tag_addr,
    input  logic                 fill_we,
    input  logic [TIDW-1:0]      fill_tid,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic [TIDW-1:0]      rd_tid,
    output logic                 rd_vld,
    output logic [AW-1:0]        rd_tag,
    output logic [LINE_BITS-1:0] rd_data
);

    logic                 vld_q  [N_THR];
    logic [AW-1:0]        tag_q  [N_THR];
    logic [LINE_BITS-1:0] data_q [N_THR];

    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        // Tag and valid bookkeeping for thread t
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[t] <= 1'b0;
                tag_q[t] <= '0;
            end else if (tag_we && tag_tid == TIDW'(t)) begin
                tag_q[t] <= tag_addr;
                vld_q[t] <= 1'b0;
            end else if (fill_we && fill_tid == TIDW'(t)) begin
                vld_q[t] <= 1'b1;
            end
        end

        // Line storage for thread t, no reset needed
        always_ff @(posedge clk) begin
            if (fill_we && fill_tid == TIDW'(t)) begin
                data_q[t] <= fill_data;
            end
        end
    end

    // Read port for the fetching thread
    always_comb begin
        rd_vld  = vld_q[rd_tid];
        rd_tag  = tag_q[rd_tid];
        rd_data = data_q[rd_tid];
    end

endmodule

// File: rtl/ifu_retry_slot.sv
// Module: single shared slot holding one refused line request.
// While the slot is busy, or after it was emptied by a squash, the block is
// blocked; blocked clears on a resend or on a ready cycle with no held request.
// Assumes cap_en is only raised while not blocked.
module ifu_retry_slot #(
    parameter int AW   = 32,
    parameter int TIDW = 1,
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [AW-1:0]   cap_addr,
    input  logic [TIDW-1:0] cap_tid,
    input  logic [ID_W-1:0] cap_id,
    input  logic            req_rdy,
    input  logic            kill_en,
    input  logic [TIDW-1:0] kill_tid,
    output logic            slot_vld,
    output logic [AW-1:0]   slot_addr,
    output logic [TIDW-1:0] slot_tid,
    output logic [ID_W-1:0] slot_id,
    output logic            blocked
);

    // Slot occupancy and blocked flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= 1'b0;
            blocked  <= 1'b0;
        end else if (cap_en) begin
            slot_vld <= 1'b1;
            blocked  <= 1'b1;
        end else if (blocked) begin
            if (slot_vld && req_rdy) begin
                slot_vld <= 1'b0;
                blocked  <= 1'b0;
            end else if (slot_vld && kill_en && kill_tid == slot_tid) begin
                slot_vld <= 1'b0;
            end else if (!slot_vld && req_rdy) begin
                blocked  <= 1'b0;
            end
        end
    end

    // Held request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_addr <= '0;
            slot_tid  <= '0;
            slot_id   <= '0;
        end else if (cap_en) begin
            slot_addr <= cap_addr;
            slot_tid  <= cap_tid;
            slot_id   <= cap_id;
        end
    end

endmodule

// File: rtl/ifu_extract.sv
// Module: combinational extraction of an instruction group from a line.
// Starts at the PC's word offset; stops at FETCH_W words, end of line, or the
// first slot whose predicted next PC is not sequential (that slot is kept).
// Assumes LINE_WORDS is a power of two and instructions are 32 bits.
module ifu_extract #(
    parameter int AW         = 32,
    parameter int LINE_WORDS = 8,
    parameter int FETCH_W    = 4,
    parameter int CNT_W      = 3,
    parameter int OFF_W      = 5
) (
    input  logic [AW-1:0]            pc,
    input  logic [LINE_WORDS*32-1:0] line_data,
    input  logic [FETCH_W*AW-1:0]    pred_npc,
    output logic [CNT_W-1:0]         cnt,
    output logic [FETCH_W*32-1:0]    insts,
    output logic [FETCH_W*AW-1:0]    pcs,
    output logic [AW-1:0]            next_pc
);

    localparam int WI_W = $clog2(LINE_WORDS) + 1;

    logic [31:0] wrd [LINE_WORDS];

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_wrd
        assign wrd[w] = line_data[w*32 +: 32];
    end

    // Walk the slots and stop at the first terminating condition
    always_comb begin
        logic          go;
        logic [WI_W-1:0] widx;
        logic [AW-1:0] spc;
        logic [AW-1:0] snpc;
        go      = 1'b1;
        cnt     = '0;
        insts   = '0;
        pcs     = '0;
        next_pc = pc;
        for (int i = 0; i < FETCH_W; i++) begin
            widx = {1'b0, pc[OFF_W-1:2]} + WI_W'(i);
            spc  = pc + AW'(4 * i);
            snpc = pred_npc[i*AW +: AW];
            if (go && widx < WI_W'(LINE_WORDS)) begin
                insts[i*32 +: 32] = wrd[widx[WI_W-2:0]];
                pcs[i*AW +: AW]   = spc;
                cnt               = cnt + CNT_W'(1);
                next_pc           = snpc;
                if (snpc != spc + AW'(4)) begin
                    go = 1'b0;
                end
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ifu_line_fetch.sv
// Module: top of the instruction line fetch unit.
// Per-thread PC and state, hit/miss decision, request issue through the
// shared retry slot, ID-matched response acceptance and registered output.
// Assumes one fetching thread per cycle and at most one response per cycle.
module ifu_line_fetch
    import ifu_pkg::*;
#(
    parameter int          N_THR      = 2,
    parameter int          AW         = 32,
    parameter int          LINE_WORDS = 8,
    parameter int          FETCH_W    = 4,
    parameter int          ID_W       = 4,
    parameter logic [31:0] RST_PC     = 32'h0,
    localparam int         TIDW       = (N_THR > 1) ? $clog2(N_THR) : 1,
    localparam int         OFF_W      = $clog2(LINE_WORDS) + 2,
    localparam int         LINE_BITS  = LINE_WORDS * 32,
    localparam int         CNT_W      = $clog2(FETCH_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fetch_go,
    input  logic [TIDW-1:0]        fetch_tid,
    output logic [AW-1:0]          fetch_pc,
    input  logic [FETCH_W*AW-1:0]  pred_npc,
    input  logic                   intr_pend,
    input  logic                   flush_vld,
    input  logic [TIDW-1:0]        flush_tid,
    input  logic [AW-1:0]          flush_pc,
    output logic                   req_vld,
    input  logic                   req_rdy,
    output logic [AW-1:0]          req_addr,
    output logic [TIDW-1:0]        req_tid,
    output logic [ID_W-1:0]        req_id,
    input  logic                   rsp_vld,
    input  logic [TIDW-1:0]        rsp_tid,
    input  logic [ID_W-1:0]        rsp_id,
    input  logic [LINE_BITS-1:0]   rsp_data,
    output logic                   rsp_stale,
    output logic                   out_vld,
    output logic [TIDW-1:0]        out_tid,
    output logic [CNT_W-1:0]       out_cnt,
    output logic [FETCH_W*32-1:0]  out_insts,
    output logic [FETCH_W*AW-1:0]  out_pcs
);

    thr_st_e              st_q  [N_THR];
    logic [AW-1:0]        pc_q  [N_THR];
    logic [ID_W-1:0]      oid_q [N_THR];
    logic [ID_W-1:0]      id_ctr;

    logic [AW-1:0]        line_addr;
    logic                 flush_me, intr_hold, can_fetch, hit;
    logic                 do_ext, do_new, resend, rsp_take;
    logic                 buf_vld;
    logic [AW-1:0]        buf_tag;
    logic [LINE_BITS-1:0] buf_data;
    logic                 slot_vld, blocked;
    logic [AW-1:0]        slot_addr;
    logic [TIDW-1:0]      slot_tid;
    logic [ID_W-1:0]      slot_id;
    logic [CNT_W-1:0]     ext_cnt;
    logic [FETCH_W*32-1:0] ext_insts;
    logic [FETCH_W*AW-1:0] ext_pcs;
    logic [AW-1:0]        ext_npc;

    // Fetch decision for the selected thread
    always_comb begin
        fetch_pc  = pc_q[fetch_tid];
        line_addr = {fetch_pc[AW-1:OFF_W], {OFF_W{1'b0}}};
        flush_me  = flush_vld && flush_tid == fetch_tid;
        intr_hold = intr_pend && fetch_pc[1:0] == 2'b00;
        can_fetch = fetch_go && st_q[fetch_tid] == TS_RUN && !flush_me
                    && !blocked && !intr_hold;
        hit       = buf_vld && buf_tag == line_addr;
        do_ext    = can_fetch && hit;
        do_new    = can_fetch && !hit;
        resend    = slot_vld && req_rdy;
    end

    // Request port mux: held request first, otherwise a new miss
    always_comb begin
        req_vld  = slot_vld || do_new;
        req_addr = slot_vld ? slot_addr : line_addr;
        req_tid  = slot_vld ? slot_tid  : fetch_tid;
        req_id   = slot_vld ? slot_id   : id_ctr;
    end

    // Response acceptance against the outstanding request of its thread
    always_comb begin
        rsp_take  = rsp_vld && st_q[rsp_tid] == TS_WAIT_RSP
                    && rsp_id == oid_q[rsp_tid]
                    && !(flush_vld && flush_tid == rsp_tid);
        rsp_stale = rsp_vld && !rsp_take;
    end

    // Request ID allocator, one ID per new request attempt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_ctr <= '0;
        end else if (do_new) begin
            id_ctr <= id_ctr + ID_W'(1);
        end
    end

    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        // Per-thread PC, state and outstanding ID update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[t]  <= TS_RUN;
                pc_q[t]  <= AW'(RST_PC);
                oid_q[t] <= '0;
            end else if (flush_vld && flush_tid == TIDW'(t)) begin
                st_q[t] <= TS_RUN;
                pc_q[t] <= flush_pc;
            end else if (rsp_take && rsp_tid == TIDW'(t)) begin
                st_q[t] <= TS_RUN;
            end else if (do_new && fetch_tid == TIDW'(t)) begin
                st_q[t]  <= req_rdy ? TS_WAIT_RSP : TS_WAIT_RETRY;
                oid_q[t] <= id_ctr;
            end else if (resend && slot_tid == TIDW'(t)) begin
                st_q[t] <= TS_WAIT_RSP;
            end else if (do_ext && fetch_tid == TIDW'(t)) begin
                pc_q[t] <= ext_npc;
            end
        end
    end

    ifu_line_buf #(
        .N_THR(N_THR), .AW(AW), .LINE_BITS(LINE_BITS), .TIDW(TIDW)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .tag_we(do_new), .tag_tid(fetch_tid), .tag_addr(line_addr),
        .fill_we(rsp_take), .fill_tid(rsp_tid), .fill_data(rsp_data),
        .rd_tid(fetch_tid), .rd_vld(buf_vld), .rd_tag(buf_tag),
        .rd_data(buf_data)
    );

    ifu_retry_slot #(
        .AW(AW), .TIDW(TIDW), .ID_W(ID_W)
    ) u_slot (
        .clk(clk), .rst_n(rst_n),
        .cap_en(do_new && !req_rdy), .cap_addr(line_addr),
        .cap_tid(fetch_tid), .cap_id(id_ctr),
        .req_rdy(req_rdy), .kill_en(flush_vld), .kill_tid(flush_tid),
        .slot_vld(slot_vld), .slot_addr(slot_addr), .slot_tid(slot_tid),
        .slot_id(slot_id), .blocked(blocked)
    );

    ifu_extract #(
        .AW(AW), .LINE_WORDS(LINE_WORDS), .FETCH_W(FETCH_W),
        .CNT_W(CNT_W), .OFF_W(OFF_W)
    ) u_ext (
        .pc(fetch_pc), .line_data(buf_data), .pred_npc(pred_npc),
        .cnt(ext_cnt), .insts(ext_insts), .pcs(ext_pcs), .next_pc(ext_npc)
    );

    // Registered instruction group toward decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_tid   <= '0;
            out_cnt   <= '0;
            out_insts <= '0;
            out_pcs   <= '0;
        end else begin
            out_vld <= do_ext;
            if (do_ext) begin
                out_tid   <= fetch_tid;
                out_cnt   <= ext_cnt;
                out_insts <= ext_insts;
                out_pcs   <= ext_pcs;
            end
        end
    end

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |-> req_addr[OFF_W-1:0] == '0);  // R1

    AST_HELD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_rdy && !(flush_vld && flush_tid == req_tid))
        |=> (req_vld && req_addr == $past(req_addr)
             && req_id == $past(req_id)));  // R3

    AST_OWNER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |-> st_q[slot_tid] == TS_WAIT_RETRY);  // R4

    AST_BLOCKED_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> !out_vld);  // R7

    AST_OUT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_cnt != '0 && out_cnt <= CNT_W'(FETCH_W)));  // R8

endmodule

// File: tb/sim_ifu_line_fetch.sv
module sim_ifu_line_fetch;

    localparam int CLK_PERIOD = 10;
    localparam int N_THR = 2, AW = 32, LW = 8, FW = 4, ID_W = 4;
    localparam int TIDW = 1, CNT_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fetch_go = 0, intr_pend = 0, flush_vld = 0, req_rdy = 1, rsp_vld = 0;
    logic [TIDW-1:0] fetch_tid = '0, flush_tid = '0, rsp_tid = '0;
    logic [AW-1:0] fetch_pc, flush_pc = '0;
    logic [FW*AW-1:0] pred_npc = '0;
    logic req_vld, rsp_stale, out_vld;
    logic [AW-1:0] req_addr;
    logic [TIDW-1:0] req_tid, out_tid;
    logic [ID_W-1:0] req_id, rsp_id = '0;
    logic [LW*32-1:0] rsp_data = '0;
    logic [CNT_W-1:0] out_cnt;
    logic [FW*32-1:0] out_insts;
    logic [FW*AW-1:0] out_pcs;

    int n_chk = 0, n_fail = 0;
    logic [AW-1:0] mpc [N_THR];

    typedef struct { int tid; int cnt; logic [31:0] pc0; string rq; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ifu_line_fetch u0 (
        .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .fetch_tid(fetch_tid),
        .fetch_pc(fetch_pc), .pred_npc(pred_npc), .intr_pend(intr_pend),
        .flush_vld(flush_vld), .flush_tid(flush_tid), .flush_pc(flush_pc),
        .req_vld(req_vld), .req_rdy(req_rdy), .req_addr(req_addr),
        .req_tid(req_tid), .req_id(req_id), .rsp_vld(rsp_vld),
        .rsp_tid(rsp_tid), .rsp_id(rsp_id), .rsp_data(rsp_data),
        .rsp_stale(rsp_stale), .out_vld(out_vld), .out_tid(out_tid),
        .out_cnt(out_cnt), .out_insts(out_insts), .out_pcs(out_pcs)
    );

    function automatic logic [31:0] inst_at(logic [31:0] a);
        return (a & 32'hFFFF_FFFC) ^ 32'hC0DE_0000;
    endfunction

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One clock: advance past the edge and clear pulse inputs
    task automatic tick();
        @(posedge clk); #1;
        fetch_go = 0; flush_vld = 0; rsp_vld = 0;
    endtask

    task automatic set_pred(int tid, logic [31:0] br_pc, logic [31:0] br_tgt);
        for (int i = 0; i < FW; i++) begin
            logic [31:0] p;
            p = mpc[tid] + 32'(4 * i);
            pred_npc[i*AW +: AW] = (p == br_pc) ? br_tgt : p + 32'd4;
        end
    endtask

    task automatic do_flush(int tid, logic [31:0] pc);
        flush_vld = 1; flush_tid = TIDW'(tid); flush_pc = pc; mpc[tid] = pc;
        tick();
    endtask

    // Fetch that must hit: no request now, group due next cycle
    task automatic fetch_hit(int tid, logic [31:0] br_pc, logic [31:0] br_tgt,
                             int cnt, string rq);
        exp_t e;
        logic [31:0] last;
        set_pred(tid, br_pc, br_tgt);
        fetch_go = 1; fetch_tid = TIDW'(tid);
        e.tid = tid; e.cnt = cnt; e.pc0 = mpc[tid]; e.rq = rq;
        exp_q.push_back(e);
        @(negedge clk);
        chk({rq, " R1 no request on hit"}, 32'(req_vld), 0);
        tick();
        last = e.pc0 + 32'(4 * (cnt - 1));
        mpc[tid] = (last == br_pc) ? br_tgt : last + 32'd4;
    endtask

    // Fetch that must miss and send a request in this cycle
    task automatic fetch_miss(int tid, logic rdy, logic [31:0] addr,
                              string rq, output logic [ID_W-1:0] id);
        set_pred(tid, 32'hFFFF_FFFF, 0);
        fetch_go = 1; fetch_tid = TIDW'(tid); req_rdy = rdy;
        @(negedge clk);
        chk({rq, " req_vld"}, 32'(req_vld), 1);
        chk({rq, " req_addr"}, req_addr, addr);
        chk({rq, " req_tid"}, 32'(req_tid), 32'(tid));
        id = req_id;
        tick();
    endtask

    task automatic respond(int tid, logic [ID_W-1:0] id, logic [31:0] line,
                           logic stale, string rq);
        rsp_vld = 1; rsp_tid = TIDW'(tid); rsp_id = id;
        for (int w = 0; w < LW; w++) rsp_data[w*32 +: 32] = inst_at(line + 32'(4*w));
        @(negedge clk);
        chk({rq, " rsp_stale"}, 32'(rsp_stale), 32'(stale));
        tick();
    endtask

    // Cycle in which nothing may be requested (blocked, waiting, interrupt)
    task automatic fetch_none(int tid, logic rdy, logic go, string rq);
        fetch_go = go; fetch_tid = TIDW'(tid); req_rdy = rdy;
        @(negedge clk);
        chk({rq, " req_vld low"}, 32'(req_vld), 0);
        tick();
    endtask

    // Monitor: compare each produced group with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected group", 32'(out_vld), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.rq, " out_tid"}, 32'(out_tid), 32'(e.tid));
                chk({e.rq, " out_cnt"}, 32'(out_cnt), 32'(e.cnt));
                for (int i = 0; i < FW; i++) begin
                    logic [31:0] p;
                    p = e.pc0 + 32'(4 * i);
                    if (i < e.cnt) begin
                        chk({e.rq, " slot pc"}, out_pcs[i*AW +: AW], p);
                        chk({e.rq, " slot inst"}, out_insts[i*32 +: 32], inst_at(p));
                    end else begin
                        chk({e.rq, " R10 unused slot"}, out_insts[i*32 +: 32]
                            | out_pcs[i*AW +: AW], 0);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [ID_W-1:0] id0, id1, id2, id3, id4, id5, id6, id7;
        mpc[0] = 0; mpc[1] = 0;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk("reset req_vld", 32'(req_vld), 0);
        chk("reset out_vld", 32'(out_vld), 0);
        chk("reset rsp_stale", 32'(rsp_stale), 0);
        @(posedge clk); #1; rst_n = 1;

        // R1 R2 miss, wait, fill, then hits
        do_flush(0, 32'h100);
        fetch_miss(0, 1, 32'h100, "R1 first miss", id0);
        fetch_none(0, 1, 1, "R2 waiting thread");
        respond(0, id0, 32'h100, 0, "R2 fill");
        fetch_hit(0, 32'hFFFF_FFFF, 0, 4, "R8 full width");
        fetch_hit(0, 32'hFFFF_FFFF, 0, 4, "R8 width meets line end");
        do_flush(0, 32'h118);
        fetch_hit(0, 32'hFFFF_FFFF, 0, 2, "R8 line end");

        // R9 predicted branch ends the group
        do_flush(0, 32'h104);
        fetch_hit(0, 32'h108, 32'h200, 2, "R9 branch in slot1");
        fetch_miss(0, 1, 32'h200, "R9 redirect miss", id1);
        respond(0, id1 + 1'b1, 32'h200, 1, "R6 wrong id");
        respond(0, id1, 32'h200, 0, "R6 right id");
        fetch_hit(0, 32'h200, 32'h20C, 1, "R9 branch in slot0");
        fetch_hit(0, 32'hFFFF_FFFF, 0, 4, "R8 mid-line start");

        // R3 R4 refused request parked and resent
        do_flush(1, 32'h344);
        fetch_miss(1, 0, 32'h340, "R3 refused", id2);
        fetch_go = 1; fetch_tid = 0; req_rdy = 0;
        @(negedge clk);
        chk("R3 held req_vld", 32'(req_vld), 1);
        chk("R3 held addr", req_addr, 32'h340);
        chk("R3 held id", 32'(req_id), 32'(id2));
        tick();
        req_rdy = 1;
        @(negedge clk);
        chk("R4 resend", 32'(req_vld), 1);
        tick();
        fetch_hit(0, 32'hFFFF_FFFF, 0, 1, "R4 unblocked");
        respond(1, id2, 32'h340, 0, "R4 resent fill");
        fetch_hit(1, 32'hFFFF_FFFF, 0, 4, "R4 thread1 hit");

        // R5 squash of the slot owner
        do_flush(1, 32'h400);
        fetch_miss(1, 0, 32'h400, "R5 refused", id3);
        do_flush(1, 32'h404);
        fetch_none(0, 0, 1, "R5 slot emptied, still blocked");
        fetch_none(0, 1, 0, "R5 clearing cycle");
        fetch_miss(0, 1, 32'h220, "R5 unblocked", id4);
        respond(0, id4, 32'h220, 0, "R5 fill");

        // R6 squash forgets the outstanding request
        fetch_miss(1, 1, 32'h400, "R6 issue", id5);
        do_flush(1, 32'h408);
        respond(1, id5, 32'h400, 1, "R6 squashed response");
        fetch_miss(1, 1, 32'h400, "R2 refetch after drop", id6);
        respond(1, id6, 32'h400, 0, "R6 fresh fill");
        fetch_hit(1, 32'hFFFF_FFFF, 0, 4, "R6 refill hit");

        // R7 interrupt hold on aligned PC, not on unaligned
        intr_pend = 1;
        fetch_none(0, 1, 1, "R7 interrupt hold");
        do_flush(1, 32'h502);
        fetch_miss(1, 1, 32'h500, "R7 unaligned pc", id7);
        intr_pend = 0;
        respond(1, id7, 32'h500, 0, "R7 fill");
        fetch_hit(0, 32'hFFFF_FFFF, 0, 4, "R7 after interrupt");
        fetch_hit(1, 32'hFFFF_FFFF, 0, 4, "R8 unaligned start");

        repeat (3) tick();
        chk("scoreboard drained", 32'(exp_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule